// File: doc/BRIEF.md
# Host I/O to Shared RAM Window Decoder

This block lets a host processor reach a local byte-wide RAM through its I/O address space. Each host strobe is checked against a small set of programmable windows. When the host address falls inside an enabled window, the block claims the cycle and turns the address into a RAM offset. A write then stores the byte in the RAM, and a read returns the stored byte one clock later. Firmware on the local side programs the windows through a compact register file and has its own port to the same RAM. Firmware uses that port to fill tables the host reads, and to pick up command data the host writes.

Each window has four settings: an enable, a base in 16-byte units, a power-of-two size, and a starting offset in the RAM. Each window also has two protection fields, one for reads and one for writes. Each field can guard the lower half of the window, the upper half, or the whole window. A blocked read returns all ones. A blocked write is dropped. Either kind of blocked access sets a sticky violation flag, which firmware clears by writing a one to it. A typical setup is a 256-byte window that the host can read and write for command traffic, together with a second window that the host can read but not write, used for a status map.

Top module: `hio_ram_window`

## Requirements
- R1: After reset, h_ack and h_rdata are 0, and every configuration register reads 0: the global enable is off and all windows are disabled.
- R2: A single-cycle h_rd or h_wr is claimed when the global enable is on and the address hits an enabled window. When a cycle is claimed, h_ack is high for exactly one clock, in the cycle after the strobe.
- R3: A window with base value B and size code n (0 to 7) covers host addresses from B*16 up to, but not including, B*16 + 16*2^n.
- R4: An unclaimed cycle gives no h_ack and leaves h_rdata at 0. A cycle is unclaimed when it misses every enabled window or when the global enable is off. h_rdata is 0 in every cycle without a read response.
- R5: The RAM address is the window's RAM-offset value times 16, plus (host address minus B*16), taken modulo the RAM size. A claimed write stores h_wdata there. A claimed read presents the stored byte on h_rdata in the cycle after the strobe.
- R6: When enabled windows overlap, window 0 serves the access.
- R7: The read-protect field encodes 00 as open, 01 as lower half guarded, 10 as upper half guarded and 11 as all guarded. The upper half is the set of offsets at or above half the window size. A claimed read of a guarded byte returns 0xFF.
- R8: The write-protect field uses the same encoding, independently of the read-protect field. A claimed write to a guarded byte leaves the RAM unchanged.
- R9: Any claimed access that is blocked sets the violation flag on the next clock. Writing 1 to the flag from the local side clears it. A blocked access in the same cycle as the clear wins, and the flag stays set.
- R10: The local RAM port reads and writes the same storage as the host, with one clock of read latency.
- R11: Configuration map. Address 0 holds the global enable in bit 0 and the violation flag in bit 1. Window w uses three addresses. Address 1+3w holds the window attributes: bit 0 enable, bits 3:1 size code, bits 5:4 read-protect, bits 7:6 write-protect. Address 2+3w holds the base, which is host address bits 11:4. Address 3+3w holds the RAM offset in 16-byte units. All fields read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | HADDR_W (16) | Host I/O address |
| h_wdata | input | DATA_W (8) | Host write data |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_rdata | output | DATA_W (8) | Host read data, valid in the cycle after a claimed read |
| h_ack | output | 1 | Cycle claimed, in the cycle after the strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | CFG_AW (3) | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, combinational |
| lram_we | input | 1 | Local RAM write enable |
| lram_addr | input | RAM_AW (11) | Local RAM address |
| lram_wdata | input | DATA_W (8) | Local RAM write data |
| lram_rdata | output | DATA_W (8) | Local RAM read data, one clock of latency |

## Verification
The embedded properties rely on three conditions at the inputs. The host never raises h_rd and h_wr in the same cycle. Each strobe lasts one clock. The local port never writes the same RAM byte in the cycle the host writes it. The stimulus keeps to these conditions: every host access is a single-cycle pulse followed by an idle cycle, the two strobes are never driven together, and local RAM writes happen only while the host side is idle. Configuration changes are also made only while no host strobe is active, so each access is decoded against settings that are stable for the whole access.

// File: rtl/hrw_pkg.sv
package hrw_pkg;

   localparam int REG_W  = 8;
   localparam int SIZE_W = 3;
   localparam int PROT_W = 2;
   localparam int UNIT_SH = 4;   // windows are placed on 16-byte units

   typedef enum logic [PROT_W-1:0] {
      GUARD_NONE  = 2'b00,
      GUARD_LOWER = 2'b01,
      GUARD_UPPER = 2'b10,
      GUARD_ALL   = 2'b11
   } guard_e;

   typedef struct packed {
      logic              en;
      logic [SIZE_W-1:0] size;
      logic [PROT_W-1:0] rguard;
      logic [PROT_W-1:0] wguard;
      logic [REG_W-1:0]  base;
      logic [REG_W-1:0]  ramoff;
   } win_cfg_t;

   function automatic logic guard_covers(input logic [PROT_W-1:0] g, input logic upper);
      unique case (g)
         GUARD_NONE:  guard_covers = 1'b0;
         GUARD_LOWER: guard_covers = ~upper;
         GUARD_UPPER: guard_covers = upper;
         default:     guard_covers = 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/hrw_regs.sv
module hrw_regs
   import hrw_pkg::*;
#(
   parameter int NUM_WIN = 2,
   parameter int CFG_AW  = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [CFG_AW-1:0]           cfg_addr,
   input  logic [REG_W-1:0]            cfg_wdata,
   input  logic                        blk_evt,
   output logic                        glb_en,
   output logic                        viol_q,
   output win_cfg_t [NUM_WIN-1:0]      win_q,
   output logic [REG_W-1:0]            cfg_rdata
);

   localparam int REGS_PER_WIN = 3;

   logic glb_sel;
   assign glb_sel = cfg_we && (cfg_addr == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glb_en <= 1'b0;
         viol_q <= 1'b0;
         win_q  <= '0;
      end else begin
         if (glb_sel)
            glb_en <= cfg_wdata[0];
         if (blk_evt)
            viol_q <= 1'b1;
         else if (glb_sel && cfg_wdata[1])
            viol_q <= 1'b0;
         for (int w = 0; w < NUM_WIN; w++) begin
            if (cfg_we && cfg_addr == CFG_AW'(1 + REGS_PER_WIN*w)) begin
               win_q[w].en     <= cfg_wdata[0];
               win_q[w].size   <= cfg_wdata[3:1];
               win_q[w].rguard <= cfg_wdata[5:4];
               win_q[w].wguard <= cfg_wdata[7:6];
            end
            if (cfg_we && cfg_addr == CFG_AW'(2 + REGS_PER_WIN*w))
               win_q[w].base <= cfg_wdata;
            if (cfg_we && cfg_addr == CFG_AW'(3 + REGS_PER_WIN*w))
               win_q[w].ramoff <= cfg_wdata;
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr == '0)
         cfg_rdata = {{(REG_W-2){1'b0}}, viol_q, glb_en};
      for (int w = 0; w < NUM_WIN; w++) begin
         if (cfg_addr == CFG_AW'(1 + REGS_PER_WIN*w))
            cfg_rdata = {win_q[w].wguard, win_q[w].rguard, win_q[w].size, win_q[w].en};
         if (cfg_addr == CFG_AW'(2 + REGS_PER_WIN*w))
            cfg_rdata = win_q[w].base;
         if (cfg_addr == CFG_AW'(3 + REGS_PER_WIN*w))
            cfg_rdata = win_q[w].ramoff;
      end
   end

   // R9
   viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_evt |=> viol_q);

   // R9
   viol_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_sel && cfg_wdata[1] && !blk_evt) |=> !viol_q);

endmodule

// File: rtl/hrw_win_match.sv
module hrw_win_match
   import hrw_pkg::*;
#(
   parameter int HADDR_W = 16,
   parameter int RAM_AW  = 11
) (
   input  win_cfg_t            cfg,
   input  logic [HADDR_W-1:0]  addr,
   output logic                hit,
   output logic                rblock,
   output logic                wblock,
   output logic [RAM_AW-1:0]   ram_addr
);

   localparam int OW = HADDR_W + 1;

   logic [OW-1:0] base_full;
   logic [OW-1:0] span;
   logic [OW-1:0] off;
   logic [OW-1:0] ram_sum;
   logic          upper;

   always_comb begin
      base_full = OW'({cfg.base, {UNIT_SH{1'b0}}});
      span      = OW'(1 << UNIT_SH) << cfg.size;
      off       = {1'b0, addr} - base_full;
      hit       = cfg.en && ({1'b0, addr} >= base_full) && (off < span);
      upper     = off >= (span >> 1);
      rblock    = guard_covers(cfg.rguard, upper);
      wblock    = guard_covers(cfg.wguard, upper);
      ram_sum   = OW'({cfg.ramoff, {UNIT_SH{1'b0}}}) + off;
      ram_addr  = ram_sum[RAM_AW-1:0];
   end

endmodule

// File: rtl/hrw_ram.sv
module hrw_ram #(
   parameter int DATA_W = 8,
   parameter int AW     = 11
) (
   input  logic              clk,
   input  logic              a_en,
   input  logic              a_we,
   input  logic [AW-1:0]     a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_we,
   input  logic [AW-1:0]     b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (a_en && a_we)
         mem[a_addr] <= a_wdata;
      if (b_we)
         mem[b_addr] <= b_wdata;
      if (a_en)
         a_rdata <= mem[a_addr];
      b_rdata <= mem[b_addr];
   end

endmodule

// File: rtl/hio_ram_window.sv
module hio_ram_window
   import hrw_pkg::*;
#(
   parameter int               NUM_WIN = 2,
   parameter int               HADDR_W = 16,
   parameter int               DATA_W  = 8,
   parameter int               RAM_AW  = 11,
   parameter logic [7:0]       RD_FILL = 8'hFF,
   localparam int              CFG_AW  = $clog2(1 + 3*NUM_WIN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [HADDR_W-1:0]  h_addr,
   input  logic [DATA_W-1:0]   h_wdata,
   input  logic                h_rd,
   input  logic                h_wr,
   output logic [DATA_W-1:0]   h_rdata,
   output logic                h_ack,
   input  logic                cfg_we,
   input  logic [CFG_AW-1:0]   cfg_addr,
   input  logic [7:0]          cfg_wdata,
   output logic [7:0]          cfg_rdata,
   input  logic                lram_we,
   input  logic [RAM_AW-1:0]   lram_addr,
   input  logic [DATA_W-1:0]   lram_wdata,
   output logic [DATA_W-1:0]   lram_rdata
);

   localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

   if (NUM_WIN < 1 || NUM_WIN > 8) begin : g_bad_num_win
      $error("hio_ram_window: NUM_WIN out of range");
   end
   if (HADDR_W < REG_W + UNIT_SH) begin : g_bad_haddr
      $error("hio_ram_window: HADDR_W too narrow for base field");
   end
   if (RAM_AW > HADDR_W + 1) begin : g_bad_ram_aw
      $error("hio_ram_window: RAM_AW wider than offset arithmetic");
   end
   if (DATA_W != REG_W) begin : g_bad_data_w
      $error("hio_ram_window: DATA_W must equal fill width");
   end

   win_cfg_t [NUM_WIN-1:0] win_cfg;
   logic                   glb_en;
   logic                   viol_q;
   logic                   blk_evt;

   logic [NUM_WIN-1:0]     hit;
   logic [NUM_WIN-1:0]     rblock;
   logic [NUM_WIN-1:0]     wblock;
   logic [RAM_AW-1:0]      waddr [NUM_WIN];

   logic [SEL_W-1:0]       sel;
   logic                   claim;
   logic                   sel_rblock;
   logic                   sel_wblock;
   logic [RAM_AW-1:0]      sel_addr;
   logic                   ram_en;
   logic                   ram_we;
   logic [DATA_W-1:0]      ram_q;

   logic                   ack_q;
   logic                   rvalid_q;
   logic                   fill_q;

   hrw_regs #(
      .NUM_WIN (NUM_WIN),
      .CFG_AW  (CFG_AW)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .blk_evt   (blk_evt),
      .glb_en    (glb_en),
      .viol_q    (viol_q),
      .win_q     (win_cfg),
      .cfg_rdata (cfg_rdata)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      hrw_win_match #(
         .HADDR_W (HADDR_W),
         .RAM_AW  (RAM_AW)
      ) u_match (
         .cfg      (win_cfg[w]),
         .addr     (h_addr),
         .hit      (hit[w]),
         .rblock   (rblock[w]),
         .wblock   (wblock[w]),
         .ram_addr (waddr[w])
      );
   end

   // lowest-numbered window wins on overlap
   always_comb begin
      sel = '0;
      for (int w = NUM_WIN-1; w >= 0; w--) begin
         if (hit[w])
            sel = SEL_W'(w);
      end
   end

   always_comb begin
      claim      = glb_en && (|hit) && (h_rd || h_wr);
      sel_rblock = rblock[sel];
      sel_wblock = wblock[sel];
      sel_addr   = waddr[sel];
      ram_en     = claim;
      ram_we     = claim && h_wr && !sel_wblock;
      blk_evt    = claim && ((h_wr && sel_wblock) || (h_rd && sel_rblock));
   end

   hrw_ram #(
      .DATA_W (DATA_W),
      .AW     (RAM_AW)
   ) u_ram (
      .clk     (clk),
      .a_en    (ram_en),
      .a_we    (ram_we),
      .a_addr  (sel_addr),
      .a_wdata (h_wdata),
      .a_rdata (ram_q),
      .b_we    (lram_we),
      .b_addr  (lram_addr),
      .b_wdata (lram_wdata),
      .b_rdata (lram_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q    <= 1'b0;
         rvalid_q <= 1'b0;
         fill_q   <= 1'b0;
      end else begin
         ack_q    <= claim;
         rvalid_q <= claim && h_rd;
         fill_q   <= claim && h_rd && sel_rblock;
      end
   end

   assign h_ack   = ack_q;
   assign h_rdata = !rvalid_q ? '0 : (fill_q ? RD_FILL : ram_q);

   // R2
   ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      h_ack |-> $past(h_rd || h_wr));

   // R4
   gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((h_rd || h_wr) && !glb_en) |=> !h_ack);

   // R7
   rd_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_rd && claim && sel_rblock) |=> (h_rdata == RD_FILL));

   // R4
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !h_ack |-> (h_rdata == '0));

endmodule

// File: tb/sim_hio_ram_window.sv
`timescale 1ns/1ps
module sim_hio_ram_window;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] h_addr = '0;
   logic [7:0]  h_wdata = '0;
   logic        h_rd = 1'b0;
   logic        h_wr = 1'b0;
   logic [7:0]  h_rdata;
   logic        h_ack;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        lram_we = 1'b0;
   logic [10:0] lram_addr = '0;
   logic [7:0]  lram_wdata = '0;
   logic [7:0]  lram_rdata;

   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   hio_ram_window u0 (
      .clk(clk), .rst_n(rst_n),
      .h_addr(h_addr), .h_wdata(h_wdata), .h_rd(h_rd), .h_wr(h_wr),
      .h_rdata(h_rdata), .h_ack(h_ack),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .lram_we(lram_we), .lram_addr(lram_addr), .lram_wdata(lram_wdata), .lram_rdata(lram_rdata)
   );

   // {wr, addr[15:0], wdata[7:0], exp_ack, exp_rdata[7:0]}
   localparam int NV = 12;
   localparam logic [33:0] VEC [NV] = '{
      {1'b1, 16'h0810, 8'hA5, 1'b1, 8'h00},
      {1'b0, 16'h0810, 8'h00, 1'b1, 8'hA5},
      {1'b1, 16'h0800, 8'hC3, 1'b1, 8'h00},
      {1'b0, 16'h0800, 8'h00, 1'b1, 8'hC3},
      {1'b1, 16'h08FF, 8'h33, 1'b1, 8'h00},
      {1'b0, 16'h08FF, 8'h00, 1'b1, 8'h33},
      {1'b0, 16'h07FF, 8'h00, 1'b0, 8'h00},
      {1'b0, 16'h0905, 8'h00, 1'b1, 8'h5A},
      {1'b1, 16'h0905, 8'h11, 1'b1, 8'h00},
      {1'b0, 16'h0905, 8'h00, 1'b1, 8'h5A},
      {1'b0, 16'h0A00, 8'h00, 1'b0, 8'h00},
      {1'b1, 16'h0A00, 8'h99, 1'b0, 8'h00}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic lram_wr(input logic [10:0] a, input logic [7:0] d);
      @(negedge clk);
      lram_we = 1'b1; lram_addr = a; lram_wdata = d;
      @(negedge clk);
      lram_we = 1'b0;
   endtask

   task automatic lram_rd(input logic [10:0] a, output logic [7:0] d);
      @(negedge clk);
      lram_addr = a;
      @(negedge clk);
      d = lram_rdata;
   endtask

   task automatic host(input logic wr, input logic [15:0] a, input logic [7:0] wd,
                       output logic ack, output logic [7:0] rd);
      @(negedge clk);
      h_addr = a; h_wdata = wd; h_wr = wr; h_rd = ~wr;
      @(negedge clk);
      ack = h_ack; rd = h_rdata;
      h_wr = 1'b0; h_rd = 1'b0;
   endtask

   task automatic host_rd_chk(input string req, input logic [15:0] a,
                              input logic eack, input logic [7:0] edata);
      logic ack;
      logic [7:0] rd;
      host(1'b0, a, 8'h00, ack, rd);
      check(req, {15'd0, ack}, {15'd0, eack});
      check(req, {8'd0, rd}, {8'd0, edata});
   endtask

   task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
      logic ack;
      logic [7:0] rd;
      host(1'b1, a, d, ack, rd);
   endtask

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1 ack", {15'd0, h_ack}, 16'd0);
      check("R1 rdata", {8'd0, h_rdata}, 16'd0);
      for (int a = 0; a < 7; a++) begin
         cfg_rd(3'(a), d);
         check("R1 cfg", {8'd0, d}, 16'd0);
      end
      // R4: global enable off, nothing claimed
      host_rd_chk("R4 gen off", 16'h0800, 1'b0, 8'h00);

      // R11: setup and readback
      cfg_wr(3'd0, 8'h01);
      cfg_wr(3'd1, 8'h09);
      cfg_wr(3'd2, 8'h80);
      cfg_wr(3'd3, 8'h00);
      cfg_wr(3'd4, 8'hC9);
      cfg_wr(3'd5, 8'h90);
      cfg_wr(3'd6, 8'h10);
      cfg_rd(3'd4, d); check("R11 attr", {8'd0, d}, 16'h00C9);
      cfg_rd(3'd5, d); check("R11 base", {8'd0, d}, 16'h0090);
      cfg_rd(3'd6, d); check("R11 ramoff", {8'd0, d}, 16'h0010);

      // R10: local fill
      lram_wr(11'h105, 8'h5A);
      lram_wr(11'h185, 8'h77);
      lram_wr(11'h110, 8'hEE);

      // R2 R3 R5 R8 main vectors
      for (int i = 0; i < NV; i++) begin
         logic ack;
         logic [7:0] rd;
         host(VEC[i][33], VEC[i][32:17], VEC[i][16:9], ack, rd);
         check("R2/R5/R8 vector ack", {15'd0, ack}, {15'd0, VEC[i][8]});
         check("R2/R5/R8 vector data", {8'd0, rd}, {8'd0, VEC[i][7:0]});
      end

      // R9: blocked write set the flag, W1C clears it
      cfg_rd(3'd0, d); check("R9 set", {8'd0, d}, 16'h0003);
      cfg_wr(3'd0, 8'h03);
      cfg_rd(3'd0, d); check("R9 clear", {8'd0, d}, 16'h0001);

      // R10: host write visible locally
      lram_rd(11'h010, d); check("R10 local read", {8'd0, d}, 16'h00A5);

      // R7: lower half read guard
      cfg_wr(3'd4, 8'hD9);
      host_rd_chk("R7 lower guarded", 16'h0905, 1'b1, 8'hFF);
      host_rd_chk("R7 upper open", 16'h0985, 1'b1, 8'h77);
      cfg_rd(3'd0, d); check("R9 read block", {8'd0, d}, 16'h0003);
      cfg_wr(3'd0, 8'h03);
      // R7: upper half read guard
      cfg_wr(3'd4, 8'hE9);
      host_rd_chk("R7 lower open", 16'h0905, 1'b1, 8'h5A);
      host_rd_chk("R7 upper guarded", 16'h0985, 1'b1, 8'hFF);

      // R8: lower half write guard
      cfg_wr(3'd4, 8'h59);
      cfg_wr(3'd4, 8'h49);
      host_wr(16'h0985, 8'h66);
      host_rd_chk("R8 upper written", 16'h0985, 1'b1, 8'h66);
      host_wr(16'h0905, 8'h22);
      host_rd_chk("R8 lower dropped", 16'h0905, 1'b1, 8'h5A);

      // R6: overlap, window 0 first
      cfg_wr(3'd5, 8'h80);
      host_rd_chk("R6 win0 priority", 16'h0810, 1'b1, 8'hA5);
      cfg_wr(3'd1, 8'h08);
      host_rd_chk("R6 win1 when win0 off", 16'h0810, 1'b1, 8'hEE);

      // R3: size codes 0 and 7
      cfg_wr(3'd4, 8'h00);
      cfg_wr(3'd1, 8'h01);
      host_wr(16'h080F, 8'h4E);
      host_rd_chk("R3 size0 last", 16'h080F, 1'b1, 8'h4E);
      host_rd_chk("R3 size0 past end", 16'h0810, 1'b0, 8'h00);
      cfg_wr(3'd1, 8'h0F);
      host_wr(16'h0FFF, 8'h7C);
      host_rd_chk("R3 size7 last", 16'h0FFF, 1'b1, 8'h7C);
      host_rd_chk("R3 size7 past end", 16'h1000, 1'b0, 8'h00);
      lram_rd(11'h7FF, d); check("R5 size7 ram addr", {8'd0, d}, 16'h007C);

      // R4: global disable
      cfg_wr(3'd0, 8'h00);
      host_rd_chk("R4 gen cleared", 16'h0800, 1'b0, 8'h00);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule